// File: doc/BRIEF.md
# Backup Supply Switchover and Access Gate

This block is the digital decision logic behind the power monitor of a battery-backed timekeeping chip. It takes three comparator flags: the main supply is above the power-fail threshold, the main supply is above the battery, and the threshold is above the battery. Each flag passes through a synchroniser and a consistency filter. From the filtered flags the block chooses whether the chip runs from the main supply or from the battery. It also decides whether the host may touch the clock registers.

The block moves to battery at one of two points. If the threshold sits below the battery voltage, the move happens as the main supply crosses the threshold. If the threshold sits above the battery voltage, the move happens only when the main supply drops under the battery. Register access is refused whenever the main supply is under the threshold. Once the supply is good again, access returns only after a recovery interval counted in clock cycles. The count starts over if the supply-good flag drops during the count. A refused request is absorbed by the gate: a write is dropped, a read returns all ones, and a one-cycle denial pulse is raised.

On the first application of power after a power-on reset, the block issues a single initialisation strobe. The strobe comes with the default calendar word that the timekeeping registers load. A sticky flag keeps the strobe from firing again on later returns from battery or on ordinary resets.

Top module: `supply_guard`

## Requirements
- R1: While rst_ni and por_ni are low, and in the cycle they are released with all flags low, on_batt_o is 1 and access_en_o, init_req_o and denied_o are 0.
- R2: A comparator flag takes effect FILT_N+2 clock edges after it changes (two synchroniser stages plus FILT_N matching samples). A change that lasts fewer than FILT_N filter samples is ignored.
- R3: With thr_gt_bat_i low, on_batt_o equals the inverse of the filtered main_ok_i. The block goes to battery when the main supply falls under the threshold, even while main_gt_bat_i is high.
- R4: With thr_gt_bat_i high, on_batt_o equals the inverse of the filtered main_gt_bat_i. While main_ok_i is low and main_gt_bat_i is high, the block stays on main power.
- R5: access_en_o is 0 in every cycle in which the filtered main_ok_i is 0, and it falls in the same cycle as that flag.
- R6: access_en_o rises exactly REC_CYC clock edges after the filtered main_ok_i rises. If the flag drops before that, the count starts over from zero at the next rise.
- R7: The first time the filtered main_ok_i is high after por_ni is released, init_req_o is high for exactly one cycle, on the edge after the flag rises. init_time_o holds {year, month, date, day, hour, minute, second} as BCD bytes with the second in bits 7:0 and its bit 7 the oscillator-halt bit, equal to 56'h00_01_01_01_00_00_00.
- R8: After the first strobe, neither a later rise of main_ok_i nor a pulse on rst_ni fires init_req_o again. Only a low pulse on por_ni re-arms it.
- R9: reg_req_o and reg_we_o follow host_req_i and host_we_i only while access_en_o is 1, and are 0 otherwise. host_rdata_o equals reg_rdata_i while access is enabled and is all ones otherwise.
- R10: A host_req_i sampled while access_en_o is 0 makes denied_o high for exactly the following cycle. A request sampled while access is enabled leaves denied_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the filters, the timer and the gate |
| por_ni | input | 1 | Active-low power-on reset; the only input that clears the first-power flag |
| main_ok_i | input | 1 | Comparator: main supply above power-fail threshold |
| main_gt_bat_i | input | 1 | Comparator: main supply above battery |
| thr_gt_bat_i | input | 1 | Comparator: threshold above battery |
| host_req_i | input | 1 | Host register access request |
| host_we_i | input | 1 | Host access is a write |
| reg_rdata_i | input | DW | Read data from the clock registers |
| on_batt_o | output | 1 | Supply select: 1 = battery, 0 = main |
| access_en_o | output | 1 | Host access to the clock registers permitted |
| reg_req_o | output | 1 | Gated request to the clock registers |
| reg_we_o | output | 1 | Gated write enable to the clock registers |
| host_rdata_o | output | DW | Read data returned to the host |
| denied_o | output | 1 | One-cycle pulse after a refused request |
| init_req_o | output | 1 | One-cycle first-power initialisation strobe |
| init_time_o | output | 56 | Default calendar word loaded on the strobe |

## Verification
The supply-select function is driven with both settings of the threshold-versus-battery flag. In one setting only the main-above-threshold flag falls; in the other only the main-above-battery flag falls. This separates the two switchover points, because each setting must react to exactly one of the two flags. A flag glitch one sample shorter than the filter window is set against longer drops, which shows that the filter depth is exact. A supply drop in the middle of a recovery count, followed by a new rise, tells a restarting counter from one that only pauses. Host requests are issued both in the enabled state and in the blocked state, and ordinary resets are compared with a power-on reset, to show the gate and the one-shot strobe.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  localparam int NUM_FLAGS       = 3;
  localparam int FLG_MAIN_OK     = 0;
  localparam int FLG_MAIN_GT_BAT = 1;
  localparam int FLG_THR_GT_BAT  = 2;

  // BCD calendar word; sec[7] is the oscillator-halt bit
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_word_t;

  function automatic cal_word_t first_power_time();
    cal_word_t w;
    w.year  = 8'h00;
    w.month = 8'h01;
    w.date  = 8'h01;
    w.dow   = 8'h01;
    w.hour  = 8'h00;
    w.min   = 8'h00;
    w.sec   = 8'h00;
    return w;
  endfunction

endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
  parameter int FILT_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);

  localparam int CW = $clog2(FILT_N) + 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);

  logic          s1_q, s2_q, flt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // flip only after FILT_N consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (s2_q != flt_q) begin
      if (cnt_q == LAST) begin
        flt_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign flt_o = flt_q;

  a_r2_flip_follows_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_q) |-> ($past(s2_q) == flt_q));

  a_r2_full_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/recovery_timer.sv
module recovery_timer #(
  parameter int REC_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  output logic acc_o
);

  localparam int CW = $clog2(REC_CYC) + 1;
  localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

  logic          acc_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (!ok_i) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (!acc_q) begin
      if (cnt_q == LAST) begin
        acc_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign acc_o = acc_q & ok_i;

  a_r6_rise_after_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_o) |-> ($past(ok_i) && $past(cnt_q) == LAST));

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int FILT_N  = 4,
  parameter int REC_CYC = 20,
  parameter int DW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          main_ok_i,
  input  logic          main_gt_bat_i,
  input  logic          thr_gt_bat_i,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          on_batt_o,
  output logic          access_en_o,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [DW-1:0] host_rdata_o,
  output logic          denied_o,
  output logic          init_req_o,
  output logic [55:0]   init_time_o
);

  logic [NUM_FLAGS-1:0] raw, flt;
  logic ok_f, gt_f, thr_f;

  assign raw[FLG_MAIN_OK]     = main_ok_i;
  assign raw[FLG_MAIN_GT_BAT] = main_gt_bat_i;
  assign raw[FLG_THR_GT_BAT]  = thr_gt_bat_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
    flag_filter #(.FILT_N(FILT_N)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .flt_o (flt[g])
    );
  end

  assign ok_f  = flt[FLG_MAIN_OK];
  assign gt_f  = flt[FLG_MAIN_GT_BAT];
  assign thr_f = flt[FLG_THR_GT_BAT];

  // switchover point depends on threshold vs battery ordering
  assign on_batt_o = thr_f ? ~gt_f : ~ok_f;

  recovery_timer #(.REC_CYC(REC_CYC)) u_rec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ok_i  (ok_f),
    .acc_o (access_en_o)
  );

  // host gate
  assign reg_req_o    = host_req_i & access_en_o;
  assign reg_we_o     = host_req_i & host_we_i & access_en_o;
  assign host_rdata_o = access_en_o ? reg_rdata_i : {DW{1'b1}};

  logic denied_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) denied_q <= 1'b0;
    else         denied_q <= host_req_i & ~access_en_o;
  end
  assign denied_o = denied_q;

  // first-power strobe; sticky flag survives rst_ni
  logic done_q, init_q;
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      done_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      init_q <= ok_f & ~done_q;
      if (ok_f) done_q <= 1'b1;
    end
  end

  assign init_req_o  = init_q;
  assign init_time_o = first_power_time();

  a_r5_blocked_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !ok_f |-> !access_en_o);

  a_r9_no_pass_when_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (reg_req_o || reg_we_o) |-> access_en_o);

  a_r3_main_when_all_high: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (ok_f && gt_f) |-> !on_batt_o);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    init_req_o |=> !init_req_o);

  a_r8_once_per_por: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(init_req_o) |-> !$past(done_q));

  a_r10_denied_cause: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    denied_o |-> $past(host_req_i && !access_en_o));

endmodule

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;

  localparam int FN  = 4;
  localparam int REC = 20;
  localparam int DW  = 8;
  localparam int LAT = FN + 2;

  localparam int S_BATT = 0, S_ACC = 1, S_INIT = 2, S_DEN = 3,
                 S_REQ = 4, S_WE = 5, S_RDATA = 6, S_ITIME = 7;

  logic clk_i = 0, rst_ni = 0, por_ni = 0;
  logic main_ok_i = 0, main_gt_bat_i = 0, thr_gt_bat_i = 0;
  logic host_req_i = 0, host_we_i = 0;
  logic [DW-1:0] reg_rdata_i = '0;
  logic on_batt_o, access_en_o, reg_req_o, reg_we_o, denied_o, init_req_o;
  logic [DW-1:0] host_rdata_o;
  logic [55:0]   init_time_o;

  supply_guard #(.FILT_N(FN), .REC_CYC(REC), .DW(DW)) u_supply_guard (
    .clk_i, .rst_ni, .por_ni, .main_ok_i, .main_gt_bat_i, .thr_gt_bat_i,
    .host_req_i, .host_we_i, .reg_rdata_i, .on_batt_o, .access_en_o,
    .reg_req_o, .reg_we_o, .host_rdata_o, .denied_o, .init_req_o, .init_time_o
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct {
    int          at;
    int          sig;
    logic [55:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic expect_at(int dt, int sig, logic [55:0] val, string tag);
    exp_t e;
    e.at = cyc + dt; e.sig = sig; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [55:0] probe(int sig);
    case (sig)
      S_BATT:  return 56'(on_batt_o);
      S_ACC:   return 56'(access_en_o);
      S_INIT:  return 56'(init_req_o);
      S_DEN:   return 56'(denied_o);
      S_REQ:   return 56'(reg_req_o);
      S_WE:    return 56'(reg_we_o);
      S_RDATA: return 56'(host_rdata_o);
      default: return init_time_o;
    endcase
  endfunction

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          logic [55:0] act;
          act = probe(q[i].sig);
          checks++;
          if (act !== q[i].val) begin
            errors++;
            $display("FAIL %s sig%0d cyc%0d actual %h expected %h",
                     q[i].tag, q[i].sig, cyc, act, q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    expect_at(0, S_BATT, 56'd1, "R1");
    expect_at(0, S_ACC,  56'd0, "R1");
    expect_at(0, S_INIT, 56'd0, "R1");
    expect_at(0, S_DEN,  56'd0, "R1");
    rst_ni = 1; por_ni = 1;
    tick(2);

    // first power-up, threshold below battery
    main_ok_i = 1; main_gt_bat_i = 1;
    expect_at(LAT-1, S_BATT, 56'd1, "R2");
    expect_at(LAT,   S_BATT, 56'd0, "R2");
    expect_at(LAT,   S_INIT, 56'd0, "R7");
    expect_at(LAT+1, S_INIT, 56'd1, "R7");
    expect_at(LAT+1, S_ITIME, 56'h00_01_01_01_00_00_00, "R7");
    expect_at(LAT+2, S_INIT, 56'd0, "R7");
    expect_at(LAT+REC-1, S_ACC, 56'd0, "R6");
    expect_at(LAT+REC,   S_ACC, 56'd1, "R6");
    tick(LAT+REC+3);

    // granted write
    host_req_i = 1; host_we_i = 1; reg_rdata_i = 8'h5A;
    expect_at(0, S_REQ,   56'd1,    "R9");
    expect_at(0, S_WE,    56'd1,    "R9");
    expect_at(0, S_RDATA, 56'h5A,   "R9");
    expect_at(1, S_DEN,   56'd0,    "R10");
    tick(1);
    host_req_i = 0; host_we_i = 0;
    tick(2);

    // glitch one sample short of the window
    main_ok_i = 0;
    tick(FN-1);
    main_ok_i = 1;
    expect_at(LAT+1, S_BATT, 56'd0, "R2");
    expect_at(LAT+1, S_ACC,  56'd1, "R2");
    expect_at(2,     S_ACC,  56'd1, "R2");
    tick(LAT+4);

    // threshold above battery
    thr_gt_bat_i = 1;
    tick(LAT+2);
    main_ok_i = 0;
    expect_at(LAT-1, S_ACC,  56'd1, "R5");
    expect_at(LAT,   S_ACC,  56'd0, "R5");
    expect_at(LAT+1, S_BATT, 56'd0, "R4");
    tick(LAT+2);
    host_req_i = 1; host_we_i = 1;
    expect_at(0, S_REQ,   56'd0,  "R9");
    expect_at(0, S_WE,    56'd0,  "R9");
    expect_at(0, S_RDATA, 56'hFF, "R9");
    expect_at(1, S_DEN,   56'd1,  "R10");
    tick(1);
    host_req_i = 0; host_we_i = 0;
    expect_at(1, S_DEN, 56'd0, "R10");
    tick(2);
    main_gt_bat_i = 0;
    expect_at(LAT-1, S_BATT, 56'd0, "R4");
    expect_at(LAT,   S_BATT, 56'd1, "R4");
    tick(LAT+2);
    main_gt_bat_i = 1;
    expect_at(LAT, S_BATT, 56'd0, "R4");
    tick(LAT+2);

    // recovery restart
    main_ok_i = 1;
    expect_at(LAT+1, S_INIT, 56'd0, "R8");
    tick(10);
    main_ok_i = 0;
    tick(8);
    main_ok_i = 1;
    expect_at(LAT+1,     S_INIT, 56'd0, "R8");
    expect_at(LAT+REC-1, S_ACC,  56'd0, "R6");
    expect_at(LAT+REC,   S_ACC,  56'd1, "R6");
    tick(LAT+REC+2);

    // threshold below battery: switch on threshold alone
    thr_gt_bat_i = 0;
    tick(LAT+2);
    main_ok_i = 0;
    expect_at(LAT-1, S_BATT, 56'd0, "R3");
    expect_at(LAT,   S_BATT, 56'd1, "R3");
    tick(LAT+2);
    main_ok_i = 1;
    expect_at(LAT, S_BATT, 56'd0, "R3");
    tick(LAT+REC+3);

    // ordinary reset keeps the sticky flag
    rst_ni = 0;
    tick(2);
    rst_ni = 1;
    expect_at(0,     S_BATT, 56'd1, "R1");
    expect_at(LAT+1, S_INIT, 56'd0, "R8");
    tick(LAT+REC+3);

    // power-on reset re-arms
    por_ni = 0;
    tick(1);
    por_ni = 1;
    expect_at(1, S_INIT, 56'd1, "R8");
    expect_at(2, S_INIT, 56'd0, "R8");
    tick(5);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule